// File: doc/BRIEF.md
# Synchronous Rectifier Gate Sequencer

This block is the digital heart of a secondary-side synchronous rectifier controller. Three comparator decisions taken on the drain-sense node reach it as logic levels: the node has dropped below the turn-on level, has climbed above the turn-off level, or has climbed above the higher re-arm level. From these levels and a supply-good flag it produces one gate-enable output. It walks the rectifier through each conduction cycle: it arms, conducts, blanks the sense input, turns off and then blanks again.

Both blanking intervals come from programmable settings. A setting counts in steps of 0.1 µs and is converted into clock cycles. A floor derived from the clock frequency applies even when the setting is zero. The off-interval timer runs only while the node stays above the re-arm level, and each ring back below that level clears it. This one rule covers two cases: ringing after a turn-off, and the first synchronisation after the supply comes up. An optional maximum conduction limit can end a cycle early. It raises a one-cycle flag when it does, so the primary side can be told that the cycle ended ahead of zero current.

All four asynchronous inputs pass through a two-flop synchroniser. A change at an input therefore shows at `gate_en` on the third rising clock edge after it is applied.

Top module: `srect_gate_ctrl`

## Requirements
- R1: `gate_en` rises only on a transition out of the armed state (state code 1), on the third rising edge after `cs_below_on` goes high. In every other state a high `cs_below_on` leaves the gate low.
- R2: Once the gate is on, `cs_above_off` has no effect until the gate has been high for the minimum on-time. If `cs_above_off` is already high at that point, the gate stays high for exactly that many cycles.
- R3: After the minimum on-time has passed (state code 3), `gate_en` falls on the third rising edge after `cs_above_off` goes high.
- R4: The block leaves the off-blank state (code 4) or the start-up wait state (code 0) for the armed state only after `cs_above_reset` has been high, as seen after synchronisation, for the full minimum off-time of consecutive cycles. A single low cycle clears the count, and the count starts again from zero.
- R5: After `supply_ok` rises, the block stays in state 0 with `armed` low until one uninterrupted off-time period has completed. `armed` then goes high together with entry into state 1.
- R6: When `supply_ok` is low (after synchronisation) or `rst_n` is low, the gate is low, the state is 0, `armed` is low and both timers are cleared.
- R7: The minimum on-time and minimum off-time equal setting × (CLK_MHZ/10) cycles. They are raised to floors of ceil(55 ns × f) and ceil(245 ns × f) cycles, which is 6 and 25 cycles at 100 MHz.
- R8: With `max_on_en` high, the gate drops after exactly max(setting × CLK_MHZ/10, minimum on-time + 1) high cycles while `cs_above_off` stays low. `maxon_trip` is then high for one cycle, in the cycle after the drop.
- R9: The maximum on-time is never shorter than the effective minimum on-time plus one cycle.
- R10: With `max_on_en` low, the gate stays high for as long as `cs_above_off` stays low.
- R11: `state` uses these codes: 0 start-up wait, 1 armed, 2 on-blank, 3 on, 4 off-blank. No other value appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, CLK_MHZ MHz |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| supply_ok | input | 1 | Supply above undervoltage level (asynchronous) |
| cs_below_on | input | 1 | Sense node below turn-on level (asynchronous) |
| cs_above_off | input | 1 | Sense node above turn-off level (asynchronous) |
| cs_above_reset | input | 1 | Sense node above re-arm level (asynchronous) |
| min_on_set | input | SET_W | Minimum on-time setting, 0.1 µs per step |
| min_off_set | input | SET_W | Minimum off-time setting, 0.1 µs per step |
| max_on_set | input | SET_W | Maximum on-time setting, 0.1 µs per step |
| max_on_en | input | 1 | Enables the maximum on-time limit |
| gate_en | output | 1 | Gate drive request |
| armed | output | 1 | First full off-time has completed since supply-up |
| maxon_trip | output | 1 | One-cycle pulse when the maximum on-time ends a cycle |
| state | output | 3 | Current sequencer state code |

## Verification
A wrong state or timer value in this block shows on `gate_en` and `state` within a few clock edges. A turn-on taken from the wrong state makes the gate rise outside state 1 on the third edge after the request. A blanking counter that fails to clear or to restart moves the entry into state 1, or the gate fall, by one or more cycles relative to the count the settings predict. For this reason the checks sample one cycle before and one cycle after each predicted transition edge. A wrong limit or a missed trip pulse shows in the single cycle that follows the predicted maximum-on edge.

// File: rtl/srg_pkg.sv
package srg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE_SYNC = 3'd0,
    ST_ARMED     = 3'd1,
    ST_ON_BLANK  = 3'd2,
    ST_ON        = 3'd3,
    ST_OFF_BLANK = 3'd4
  } srg_state_e;

endpackage

// File: rtl/srg_sync.sv
// Multi-bit two-or-more stage synchroniser, each bit independent.
module srg_sync #(
  parameter int W = 4,
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [N];

  generate
    for (genvar i = 0; i < N; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[0] <= '0;
          else        stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[i] <= '0;
          else        stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign q = stg[N-1];

endmodule

// File: rtl/srg_timer.sv
// Saturating up-counter with a synchronous clear that takes priority.
module srg_timer #(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);

  logic             cnt_en;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_en = clr || (cnt != '1);
    cnt_d  = clr ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_d;
  end

endmodule

// File: rtl/srg_limit.sv
// Converts a 0.1 us step setting into cycles and applies a lower bound.
module srg_limit #(
  parameter int SET_W = 9,
  parameter int CNT_W = 13,
  parameter int STEP  = 10
) (
  input  logic [SET_W-1:0] setting,
  input  logic [CNT_W-1:0] floor_cyc,
  output logic [CNT_W-1:0] cyc
);

  logic [CNT_W-1:0] scaled;

  always_comb begin
    scaled = CNT_W'(setting) * CNT_W'(STEP);
    cyc    = (scaled < floor_cyc) ? floor_cyc : scaled;
  end

endmodule

// File: rtl/srect_gate_ctrl.sv
module srect_gate_ctrl
  import srg_pkg::*;
#(
  parameter int CLK_MHZ = 100,
  parameter int SET_W   = 9,
  parameter int SYNC_N  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             supply_ok,
  input  logic             cs_below_on,
  input  logic             cs_above_off,
  input  logic             cs_above_reset,
  input  logic [SET_W-1:0] min_on_set,
  input  logic [SET_W-1:0] min_off_set,
  input  logic [SET_W-1:0] max_on_set,
  input  logic             max_on_en,
  output logic             gate_en,
  output logic             armed,
  output logic             maxon_trip,
  output logic [2:0]       state
);

  localparam int STEP_RAW  = CLK_MHZ / 10;
  localparam int STEP      = (STEP_RAW < 1) ? 1 : STEP_RAW;
  localparam int MAX_CYC   = ((1 << SET_W) - 1) * STEP + 2;
  localparam int CNT_W     = $clog2(MAX_CYC + 1);
  localparam int ON_FL_RAW = (55 * CLK_MHZ + 999) / 1000;
  localparam int OFF_FL_RAW = (245 * CLK_MHZ + 999) / 1000;
  localparam int ON_FLOOR  = (ON_FL_RAW < 1) ? 1 : ON_FL_RAW;
  localparam int OFF_FLOOR = (OFF_FL_RAW < 1) ? 1 : OFF_FL_RAW;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  // input synchronisers
  logic [3:0] raw_in, syn_in;
  logic       sup_s, on_s, off_s, rst_s;

  assign raw_in = {supply_ok, cs_below_on, cs_above_off, cs_above_reset};

  srg_sync #(.W(4), .N(SYNC_N)) u_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .d     (raw_in),
    .q     (syn_in)
  );

  assign {sup_s, on_s, off_s, rst_s} = syn_in;

  // effective limits in cycles
  logic [CNT_W-1:0] min_on_cyc, min_off_cyc, max_on_cyc, max_floor;

  srg_limit #(.SET_W(SET_W), .CNT_W(CNT_W), .STEP(STEP)) u_lim_on (
    .setting   (min_on_set),
    .floor_cyc (CNT_W'(ON_FLOOR)),
    .cyc       (min_on_cyc)
  );

  srg_limit #(.SET_W(SET_W), .CNT_W(CNT_W), .STEP(STEP)) u_lim_off (
    .setting   (min_off_set),
    .floor_cyc (CNT_W'(OFF_FLOOR)),
    .cyc       (min_off_cyc)
  );

  assign max_floor = min_on_cyc + 1'b1;

  srg_limit #(.SET_W(SET_W), .CNT_W(CNT_W), .STEP(STEP)) u_lim_max (
    .setting   (max_on_set),
    .floor_cyc (max_floor),
    .cyc       (max_on_cyc)
  );

  // state register and timers
  srg_state_e       st_q, st_d;
  logic             armed_q, armed_d, trip_q, trip_d;
  logic [CNT_W-1:0] on_cnt, off_cnt;
  logic             on_clr, off_clr;
  logic             in_on, in_off;
  logic             on_done, off_done, max_hit;

  assign in_on  = (st_q == ST_ON_BLANK) || (st_q == ST_ON);
  assign in_off = (st_q == ST_OFF_BLANK) || (st_q == ST_IDLE_SYNC);
  assign on_clr  = !sup_s || !in_on;
  assign off_clr = !sup_s || !in_off || !rst_s;

  srg_timer #(.CNT_W(CNT_W)) u_on_tmr (
    .clk   (clk),
    .rst_n (rst_core_n),
    .clr   (on_clr),
    .cnt   (on_cnt)
  );

  srg_timer #(.CNT_W(CNT_W)) u_off_tmr (
    .clk   (clk),
    .rst_n (rst_core_n),
    .clr   (off_clr),
    .cnt   (off_cnt)
  );

  assign on_done  = (on_cnt  == min_on_cyc  - 1'b1);
  assign off_done = rst_s && (off_cnt == min_off_cyc - 1'b1);
  assign max_hit  = max_on_en && (on_cnt == max_on_cyc - 1'b1);

  always_comb begin
    st_d    = st_q;
    armed_d = armed_q;
    trip_d  = 1'b0;
    if (!sup_s) begin
      st_d    = ST_IDLE_SYNC;
      armed_d = 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE_SYNC, ST_OFF_BLANK: begin
          if (off_done) begin
            st_d    = ST_ARMED;
            armed_d = 1'b1;
          end
        end
        ST_ARMED: begin
          if (on_s) st_d = ST_ON_BLANK;
        end
        ST_ON_BLANK: begin
          if (on_done) st_d = off_s ? ST_OFF_BLANK : ST_ON;
        end
        ST_ON: begin
          if (off_s) begin
            st_d = ST_OFF_BLANK;
          end else if (max_hit) begin
            st_d   = ST_OFF_BLANK;
            trip_d = 1'b1;
          end
        end
        default: st_d = ST_IDLE_SYNC;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      st_q    <= ST_IDLE_SYNC;
      armed_q <= 1'b0;
      trip_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      armed_q <= armed_d;
      trip_q  <= trip_d;
    end
  end

  assign gate_en    = in_on;
  assign armed      = armed_q;
  assign maxon_trip = trip_q;
  assign state      = st_q;

endmodule

// File: rtl/srg_checks.sv
module srg_checks #(
  parameter int CLK_MHZ = 100
) (
  input logic       clk,
  input logic       rst_n,
  input logic       supply_ok,
  input logic       gate_en,
  input logic       armed,
  input logic       maxon_trip,
  input logic [2:0] state
);

  localparam int ONF_RAW = (55 * CLK_MHZ + 999) / 1000;
  localparam int ONF     = (ONF_RAW < 1) ? 1 : ONF_RAW;

  logic [2:0]  sup_run;
  logic [15:0] hi_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sup_run <= '0;
      hi_len  <= '0;
    end else begin
      sup_run <= !supply_ok ? 3'd0 : ((sup_run == 3'd7) ? sup_run : sup_run + 3'd1);
      hi_len  <= !gate_en ? 16'd0 : ((hi_len == '1) ? hi_len : hi_len + 16'd1);
    end
  end

  p_rise_from_armed_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_en) |-> $past(state) == 3'd1);

  p_on_floor_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(gate_en) && sup_run == 3'd7) |-> hi_len >= 16'(ONF));

  p_armed_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> state == 3'd1);

  p_supply_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!supply_ok && $past(!supply_ok) && $past(!supply_ok, 2)) |=> (!gate_en && !armed && state == 3'd0));

  p_trip_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    maxon_trip |-> (!gate_en && state == 3'd4 && $past(gate_en)));

  p_legal_state_r11: assert property (@(posedge clk) disable iff (!rst_n)
    state <= 3'd4);

endmodule

bind srect_gate_ctrl srg_checks #(.CLK_MHZ(CLK_MHZ)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .supply_ok  (supply_ok),
  .gate_en    (gate_en),
  .armed      (armed),
  .maxon_trip (maxon_trip),
  .state      (state)
);

// File: tb/sim_srect_gate_ctrl.sv
module sim_srect_gate_ctrl;

  localparam int SET_W = 9;
  localparam logic [2:0] S_IDLE = 3'd0, S_ARM = 3'd1, S_ONB = 3'd2, S_ON = 3'd3, S_OFFB = 3'd4;

  typedef struct packed {
    logic       sup;
    logic       bon;
    logic       aoff;
    logic       arst;
    logic [7:0] n;
    logic       gate;
    logic [2:0] st;
    logic [3:0] req;
  } row_t;

  // min_on = 20 cycles, min_off = 30 cycles for the table
  localparam int NROW = 18;
  localparam row_t TBL [NROW] = '{
    '{1'b1, 1'b1, 1'b0, 1'b0, 8'd40, 1'b0, S_IDLE, 4'd5}, // R5 no gate before sync
    '{1'b1, 1'b0, 1'b1, 1'b1, 8'd20, 1'b0, S_IDLE, 4'd4}, // R4 partial period
    '{1'b1, 1'b0, 1'b1, 1'b0, 8'd5,  1'b0, S_IDLE, 4'd4}, // R4 dip clears
    '{1'b1, 1'b0, 1'b1, 1'b1, 8'd31, 1'b0, S_IDLE, 4'd4}, // R4 one cycle short
    '{1'b1, 1'b0, 1'b1, 1'b1, 8'd1,  1'b0, S_ARM,  4'd5}, // R5 synced
    '{1'b1, 1'b1, 1'b0, 1'b0, 8'd2,  1'b0, S_ARM,  4'd1}, // R1 latency, not yet
    '{1'b1, 1'b1, 1'b0, 1'b0, 8'd1,  1'b1, S_ONB,  4'd1}, // R1 gate on
    '{1'b1, 1'b0, 1'b1, 1'b0, 8'd10, 1'b1, S_ONB,  4'd2}, // R2 off ignored
    '{1'b1, 1'b0, 1'b1, 1'b0, 8'd9,  1'b1, S_ONB,  4'd2}, // R2 still blanking
    '{1'b1, 1'b0, 1'b1, 1'b0, 8'd1,  1'b0, S_OFFB, 4'd2}, // R2 drop at min on
    '{1'b1, 1'b0, 1'b1, 1'b1, 8'd20, 1'b0, S_OFFB, 4'd4}, // R4 off blank running
    '{1'b1, 1'b1, 1'b0, 1'b0, 8'd5,  1'b0, S_OFFB, 4'd1}, // R1 ringing ignored
    '{1'b1, 1'b0, 1'b1, 1'b1, 8'd31, 1'b0, S_OFFB, 4'd4}, // R4 restart, short
    '{1'b1, 1'b0, 1'b1, 1'b1, 8'd1,  1'b0, S_ARM,  4'd4}, // R4 full period
    '{1'b1, 1'b1, 1'b0, 1'b0, 8'd3,  1'b1, S_ONB,  4'd1}, // R1 second turn-on
    '{1'b1, 1'b1, 1'b0, 1'b0, 8'd25, 1'b1, S_ON,   4'd11}, // R11 on code
    '{1'b1, 1'b0, 1'b1, 1'b0, 8'd2,  1'b1, S_ON,   4'd3}, // R3 latency
    '{1'b1, 1'b0, 1'b1, 1'b0, 8'd1,  1'b0, S_OFFB, 4'd3}  // R3 turned off
  };

  logic clk = 1'b0;
  logic rst_n;
  logic supply_ok, cs_below_on, cs_above_off, cs_above_reset, max_on_en;
  logic [SET_W-1:0] min_on_set, min_off_set, max_on_set;
  logic gate_en, armed, maxon_trip;
  logic [2:0] state;

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  srect_gate_ctrl #(.CLK_MHZ(100), .SET_W(SET_W)) u0 (
    .clk            (clk),
    .rst_n          (rst_n),
    .supply_ok      (supply_ok),
    .cs_below_on    (cs_below_on),
    .cs_above_off   (cs_above_off),
    .cs_above_reset (cs_above_reset),
    .min_on_set     (min_on_set),
    .min_off_set    (min_off_set),
    .max_on_set     (max_on_set),
    .max_on_en      (max_on_en),
    .gate_en        (gate_en),
    .armed          (armed),
    .maxon_trip     (maxon_trip),
    .state          (state)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic s, input logic b, input logic o, input logic r);
    supply_ok = s; cs_below_on = b; cs_above_off = o; cs_above_reset = r;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic gs(input string req, input int g, input int s);
    check(req, "gate_en", int'(gate_en), g);
    check(req, "state", int'(state), s);
  endtask

  // from off-blank: hold the node above re-arm until armed (R4)
  task automatic rearm();
    drive(1, 0, 1, 1);
    wait_cyc(40);
    gs("R4", 0, S_ARM);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    drive(0, 0, 1, 1);
    min_on_set = 9'd2; min_off_set = 9'd3; max_on_set = 9'd5; max_on_en = 1'b0;
    wait_cyc(5);
    // R6 reset state
    gs("R6", 0, S_IDLE);
    check("R6", "armed", int'(armed), 0);
    check("R8", "maxon_trip", int'(maxon_trip), 0);
    rst_n = 1'b1;
    wait_cyc(4);

    for (int k = 0; k < NROW; k++) begin
      drive(TBL[k].sup, TBL[k].bon, TBL[k].aoff, TBL[k].arst);
      wait_cyc(int'(TBL[k].n));
      check($sformatf("R%0d row%0d", TBL[k].req, k), "gate_en", int'(gate_en), int'(TBL[k].gate));
      check($sformatf("R%0d row%0d", TBL[k].req, k), "state", int'(state), int'(TBL[k].st));
      if (k == 4) check("R5", "armed", int'(armed), 1);
    end

    // R7 off-time floor: setting 0 gives 25 cycles
    min_off_set = 9'd0;
    drive(1, 0, 1, 1);
    wait_cyc(26);
    gs("R7 off floor short", 0, S_OFFB);
    wait_cyc(1);
    gs("R7 off floor", 0, S_ARM);

    // R7 on-time floor: setting 0 gives 6 cycles
    min_on_set = 9'd0;
    drive(1, 1, 1, 0);
    wait_cyc(8);
    gs("R7 on floor held", 1, S_ONB);
    wait_cyc(1);
    gs("R7 on floor drop", 0, S_OFFB);
    min_on_set = 9'd2; min_off_set = 9'd3;

    // R8 maximum on-time: 50 cycles
    rearm();
    max_on_en = 1'b1; max_on_set = 9'd5;
    drive(1, 1, 0, 0);
    wait_cyc(52);
    gs("R8 before limit", 1, S_ON);
    check("R8", "maxon_trip", int'(maxon_trip), 0);
    wait_cyc(1);
    gs("R8 at limit", 0, S_OFFB);
    check("R8", "maxon_trip", int'(maxon_trip), 1);
    wait_cyc(1);
    check("R8 pulse width", "maxon_trip", int'(maxon_trip), 0);

    // R9 maximum raised to min_on + 1 = 21
    rearm();
    max_on_set = 9'd1;
    drive(1, 1, 0, 0);
    wait_cyc(23);
    gs("R9 before limit", 1, S_ON);
    wait_cyc(1);
    gs("R9 at limit", 0, S_OFFB);
    check("R9", "maxon_trip", int'(maxon_trip), 1);

    // R10 limit disabled
    rearm();
    max_on_en = 1'b0;
    drive(1, 1, 0, 0);
    wait_cyc(120);
    gs("R10", 1, S_ON);
    check("R10", "maxon_trip", int'(maxon_trip), 0);

    // R6 supply drop while conducting
    drive(0, 1, 0, 0);
    wait_cyc(2);
    gs("R6 latency", 1, S_ON);
    wait_cyc(1);
    gs("R6 supply low", 0, S_IDLE);
    check("R6", "armed", int'(armed), 0);

    // R5 resync after supply returns
    drive(1, 0, 1, 1);
    wait_cyc(31);
    gs("R5 resync short", 0, S_IDLE);
    check("R5", "armed", int'(armed), 0);
    wait_cyc(1);
    gs("R5 resync", 0, S_ARM);
    check("R5", "armed", int'(armed), 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule